// File: doc/BRIEF.md
# Threshold Window Comparator with Hysteresis

This block watches a stream of unsigned measurement results and decides, for each new result, whether it lies in the region selected by a 3-bit mode. The region is defined relative to a programmable low bound and high bound. A result is presented together with a single-cycle strobe. In the cycle after the strobe the block shows the updated window level. If that level is active, it also emits a one-cycle hit pulse that a neighbouring flag or event path can consume.

Four of the modes are stateless. They compare against one bound or both bounds: above the low bound, below the high bound, strictly between the bounds, or outside them. Two further modes add hysteresis, and in these the level is latched. In the rising-hysteresis mode the level is set by a result above the high bound and released only by a result below the low bound. The falling-hysteresis mode does the mirror image. Mode 0 and the reserved code 7 turn the comparison off. Any change of mode, and reset, clear the latched level.

Top module: `win_cmp`

## Requirements
- R1: After reset `win_hit` and `win_level` are both 0.
- R2: With `mode` = 0 or 7, a strobed result gives `win_hit` = 0 and `win_level` = 0 in the following cycle.
- R3: With `mode` = 1, the level after a strobe is 1 exactly when the result is strictly greater than `thr_lo`.
- R4: With `mode` = 2, the level after a strobe is 1 exactly when the result is strictly less than `thr_hi`.
- R5: With `mode` = 3, the level after a strobe is 1 exactly when `thr_lo` < result < `thr_hi`, both comparisons strict.
- R6: With `mode` = 4, the level after a strobe is 1 exactly when the result is < `thr_lo` or > `thr_hi`.
- R7: With `mode` = 5, a result > `thr_hi` sets the level and a result < `thr_lo` clears it. Any other result, including one equal to either bound, leaves the level unchanged. When both conditions hold at once, setting wins.
- R8: With `mode` = 6, a result < `thr_lo` sets the level and a result > `thr_hi` clears it. Any other result leaves the level unchanged. When both conditions hold at once, setting wins.
- R9: `win_hit` is high only in the cycle right after a strobe, and then it equals the new level. In every other cycle it is 0.
- R10: Without a strobe and without a change of mode, `win_level` keeps its value.
- R11: When `mode` differs from its value in the previous cycle, the latched level is cleared. A strobe in that same cycle is evaluated against a cleared prior level.
- R12: All comparisons are unsigned over the full 24 bits. For example, 0x800000 counts as greater than 0x7FFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | One-cycle strobe marking a new result |
| res_value | input | 24 | Measurement result, unsigned |
| thr_lo | input | 24 | Low bound, unsigned |
| thr_hi | input | 24 | High bound, unsigned |
| mode | input | 3 | Window mode: 0 off, 1 above-low, 2 below-high, 3 inside, 4 outside, 5 rising hysteresis, 6 falling hysteresis, 7 off |
| win_hit | output | 1 | One-cycle pulse when a strobed result leaves the level active |
| win_level | output | 1 | Current window level |

## Verification
On every cycle the assertions check the following: a hit is never raised without a strobe in the previous cycle, and a hit always goes with an active level; the off modes clear the level; the level holds between strobes; a mode change clears it; and the simple above-low mode tracks its comparison. Only the bench scenarios can show the hysteresis paths, the bounds on both sides of each strict comparison, and the unsigned treatment of the top bit. The hysteresis paths are set, hold at a bound, release, and the set-over-release precedence. The bench's reference model, compared every clock, also covers the order of mode changes relative to strobes.

// File: rtl/win_cmp.sv
module win_cmp #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         res_valid,
  input  logic [W-1:0] res_value,
  input  logic [W-1:0] thr_lo,
  input  logic [W-1:0] thr_hi,
  input  logic [2:0]   mode,
  output logic         win_hit,
  output logic         win_level
);

  logic       gt_lo, lt_lo, gt_hi, lt_hi;
  logic       mode_chg, prior, eval;
  logic [2:0] mode_q;
  logic       level_q, hit_q;

  assign gt_lo    = res_value > thr_lo;
  assign lt_lo    = res_value < thr_lo;
  assign gt_hi    = res_value > thr_hi;
  assign lt_hi    = res_value < thr_hi;
  assign mode_chg = mode != mode_q;
  assign prior    = mode_chg ? 1'b0 : level_q;

  always_comb begin
    case (mode)
      3'd1:    eval = gt_lo;
      3'd2:    eval = lt_hi;
      3'd3:    eval = gt_lo & lt_hi;
      3'd4:    eval = lt_lo | gt_hi;
      3'd5:    eval = gt_hi ? 1'b1 : (lt_lo ? 1'b0 : prior);
      3'd6:    eval = lt_lo ? 1'b1 : (gt_hi ? 1'b0 : prior);
      default: eval = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 3'd0;
      level_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      mode_q <= mode;
      if (res_valid) begin
        level_q <= eval;
        hit_q   <= eval;
      end else begin
        level_q <= prior;
        hit_q   <= 1'b0;
      end
    end
  end

  assign win_hit   = hit_q;
  assign win_level = level_q;

endmodule

// File: rtl/win_cmp_chk.sv
module win_cmp_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         res_valid,
  input logic [W-1:0] res_value,
  input logic [W-1:0] thr_lo,
  input logic [W-1:0] thr_hi,
  input logic [2:0]   mode,
  input logic         win_hit,
  input logic         win_level
);

  // R9
  hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> $past(res_valid));

  // R9
  hit_with_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> win_level);

  // R2
  off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (mode == 3'd0 || mode == 3'd7)) |=> (!win_hit && !win_level));

  // R10
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && mode == $past(mode)) |=> (win_level == $past(win_level)));

  // R11
  mode_change_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && mode != $past(mode)) |=> !win_level);

  // R3
  above_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode == 3'd1) |=> (win_hit == $past(res_value > thr_lo)));

endmodule

bind win_cmp win_cmp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
  .thr_lo(thr_lo), .thr_hi(thr_hi), .mode(mode),
  .win_hit(win_hit), .win_level(win_level)
);

// File: tb/sim_win_cmp.sv
`timescale 1ns/1ps
module sim_win_cmp;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         res_valid = 1'b0;
  logic [W-1:0] res_value = '0;
  logic [W-1:0] thr_lo = '0;
  logic [W-1:0] thr_hi = '0;
  logic [2:0]   mode = 3'd0;
  logic         win_hit, win_level;

  int    n_run = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #4 clk = ~clk;

  win_cmp #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .mode(mode),
    .win_hit(win_hit), .win_level(win_level)
  );

  logic       m_lvl = 1'b0, m_hit = 1'b0;
  logic [2:0] m_prev = 3'd0;

  always @(posedge clk or negedge rst_n) begin
    logic base, r;
    if (!rst_n) begin
      m_lvl = 0; m_hit = 0; m_prev = 0;
    end else begin
      base = (mode != m_prev) ? 1'b0 : m_lvl;
      r = 1'b0;
      if (mode == 1) r = res_value > thr_lo;
      else if (mode == 2) r = res_value < thr_hi;
      else if (mode == 3) r = (res_value > thr_lo) && (res_value < thr_hi);
      else if (mode == 4) r = (res_value < thr_lo) || (res_value > thr_hi);
      else if (mode == 5) begin
        if (res_value > thr_hi) r = 1; else if (res_value < thr_lo) r = 0; else r = base;
      end else if (mode == 6) begin
        if (res_value < thr_lo) r = 1; else if (res_value > thr_hi) r = 0; else r = base;
      end
      if (res_valid) begin m_lvl = r; m_hit = r; end
      else begin m_lvl = base; m_hit = 0; end
      m_prev = mode;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_run++;
      if (win_hit !== m_hit || win_level !== m_lvl) begin
        n_fail++;
        $display("FAIL %s model: hit=%b level=%b expected hit=%b level=%b",
                 cur_req, win_hit, win_level, m_hit, m_lvl);
      end
    end
  end

  task automatic chk(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] v, input logic exp);
    @(negedge clk);
    res_valid = 1'b1; res_value = v;
    @(negedge clk);
    res_valid = 1'b0;
    chk(cur_req, win_hit, exp);
    chk(cur_req, win_level, exp);
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode = m;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", win_hit, 1'b0);
    chk("R1", win_level, 1'b0);
    rst_n = 1'b1;
    thr_lo = 24'd10; thr_hi = 24'd100;

    cur_req = "R2";
    send(24'd50, 1'b0);
    set_mode(3'd7);
    send(24'd50, 1'b0);

    cur_req = "R3"; set_mode(3'd1);
    send(24'd11, 1'b1); send(24'd10, 1'b0); send(24'd5, 1'b0);

    cur_req = "R4"; set_mode(3'd2);
    send(24'd99, 1'b1); send(24'd100, 1'b0);

    cur_req = "R5"; set_mode(3'd3);
    send(24'd50, 1'b1); send(24'd10, 1'b0); send(24'd100, 1'b0);

    cur_req = "R6"; set_mode(3'd4);
    send(24'd9, 1'b1); send(24'd101, 1'b1); send(24'd50, 1'b0); send(24'd10, 1'b0);

    cur_req = "R7"; set_mode(3'd5);
    send(24'd50, 1'b0); send(24'd101, 1'b1);
    @(negedge clk);
    chk("R9", win_hit, 1'b0);
    chk("R10", win_level, 1'b1);
    send(24'd50, 1'b1); send(24'd100, 1'b1); send(24'd10, 1'b1);
    send(24'd9, 1'b0); send(24'd50, 1'b0);
    send(24'd200, 1'b1);

    cur_req = "R11"; set_mode(3'd6);
    @(negedge clk);
    chk("R11", win_level, 1'b0);

    cur_req = "R8";
    send(24'd50, 1'b0); send(24'd9, 1'b1); send(24'd50, 1'b1);
    send(24'd100, 1'b1); send(24'd101, 1'b0);
    thr_lo = 24'd100; thr_hi = 24'd10;
    send(24'd50, 1'b1);
    thr_lo = 24'd10; thr_hi = 24'd100;

    cur_req = "R11";
    send(24'd9, 1'b1);
    @(negedge clk);
    mode = 3'd5; res_valid = 1'b1; res_value = 24'd50;
    @(negedge clk);
    res_valid = 1'b0;
    chk("R11", win_level, 1'b0);

    cur_req = "R12"; set_mode(3'd1);
    thr_lo = 24'h7FFFFF;
    send(24'h800000, 1'b1);
    set_mode(3'd2);
    thr_hi = 24'h800000;
    send(24'hFFFFFF, 1'b0);

    cur_req = "R9";
    repeat (3) @(negedge clk);
    chk("R9", win_hit, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule